// File: doc/BRIEF.md
# Pipelined ADC Conversion Sequence Timer

This block schedules conversions for a pipelined sampling converter. It models the timing only. After a start trigger it drives the sample-and-hold window for each conversion and reports which channel or pair is being sampled. It then issues result strobes at the times a pipelined converter would deliver results. Each strobe carries a slot number and a placeholder result code built from that slot. The block has two modes. In sequential mode it runs one conversion per slot. In pair mode, two channels are sampled together in each window, and the two results come out one conversion tick apart.

All timing is counted in conversion ticks. A tick is a clock cycle in which `clk_en` is high, and no state moves in any other cycle. The acquisition setting, the conversion count and the mode are captured when the trigger is accepted. The continuous-run input is read at the end of each sequence's final window. If it is set, the next sequence starts with no gap.

The controller is one state machine with four states. ST_IDLE waits for the trigger. ST_ACQUIRE holds the sample window open. ST_SETTLE is the gap between windows. ST_DRAIN waits for the last result after sampling stops. Its transitions are:
- start: ST_IDLE to ST_ACQUIRE on an accepted trigger.
- window-done: ST_ACQUIRE to ST_SETTLE when more slots remain, or when the sequence is done with continuous run set.
- stop: ST_ACQUIRE to ST_DRAIN on the final window with continuous run clear.
- reopen: ST_SETTLE to ST_ACQUIRE after the gap.
- finish: ST_DRAIN to ST_IDLE on the tick that shows the end-of-sequence flag.

Top module: `adc_seq_timer`

## Requirements
- R1: After reset, `sh_pulse`, `res_valid_a`, `res_valid_b`, `eos`, `chan_idx`, `res_code_a` and `res_code_b` are all zero.
- R2: Each sample window holds `sh_pulse` high for `acq_ps`+1 consecutive ticks, and `chan_idx` shows the slot (sequential) or pair number (pair mode) during the window. The first window opens on the tick after the trigger tick.
- R3: The first result of a sequence is valid `acq_ps`+1+4 ticks after the tick in which the trigger was accepted.
- R4: In sequential mode, consecutive results, and consecutive window openings, are spaced `acq_ps`+2 ticks apart. Results carry slots 0, 1, 2 and so on.
- R5: In pair mode (`mode_simul`=1), consecutive pairs, and consecutive window openings, are spaced `acq_ps`+4 ticks apart.
- R6: In pair mode, the first result of pair p appears on `res_valid_a` with slot 2p. The second appears on `res_valid_b` one tick later with slot 2p+1. `res_valid_b` never rises in sequential mode.
- R7: A count field of N gives N+1 conversions in sequential mode, using all 4 bits. In pair mode it gives N[2:0]+1 pairs, and bit 3 is ignored. `eos` is high for exactly one tick: with the last sequential result, or with the last pair's second result.
- R8: With `cont_run` set, a single trigger produces back-to-back sequences with no gap. The slot returns to 0 after each sequence, `eos` marks each sequence's end, and clearing `cont_run` stops sampling after the current sequence.
- R9: A trigger is accepted only in ST_IDLE. A trigger, mode change or setting change that arrives while a sequence is active has no effect on the running sequence's timing, mode or count.
- R10: In cycles where `clk_en` is low, no output changes. All of the timing above holds in enabled ticks.
- R11: `res_code_a` and `res_code_b` equal {8'hC3, slot} while their strobe is high, and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Conversion tick enable |
| soc | input | 1 | Start trigger, sampled on a tick |
| mode_simul | input | 1 | 1 = pair mode, 0 = sequential |
| acq_ps | input | 6 | Window stretch; the window is acq_ps+1 ticks |
| max_conv | input | 4 | Conversion count minus one (pair mode uses bits 2:0) |
| cont_run | input | 1 | Repeat sequences without new triggers |
| sh_pulse | output | 1 | Sample-and-hold window |
| chan_idx | output | 4 | Slot or pair being sampled, zero outside a window |
| res_valid_a | output | 1 | Result strobe (first channel in pair mode) |
| res_slot_a | output | 4 | Slot of the result on res_valid_a |
| res_code_a | output | 12 | Placeholder result code for res_valid_a |
| res_valid_b | output | 1 | Second-channel result strobe in pair mode |
| res_slot_b | output | 4 | Slot of the result on res_valid_b |
| res_code_b | output | 12 | Placeholder result code for res_valid_b |
| eos | output | 1 | End of sequence, with the sequence's last result |

## Verification
The assertions assume that `acq_ps` and `max_conv` are only used after they have been captured at a trigger, so the interval and window-width properties are measured against the captured values rather than the live inputs. They also assume that `clk_en` is the only gating, so each strobe occupies a single enabled tick. The stimulus changes its inputs only between edges, triggers only on enabled cycles, and drives `clk_en` either held high or alternating every cycle. Mid-sequence changes to mode and settings occur only in the test that is meant to show they are ignored.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_DRAIN   = 2'd3
    } seq_state_e;

    // Ticks between the end of one window and the start of the next
    localparam int SEQ_SETTLE_TICKS  = 1;
    localparam int PAIR_SETTLE_TICKS = 3;
    localparam int SETTLE_W          = 2;

endpackage

// File: rtl/adc_seq_sampler.sv
`timescale 1ns/1ps
module adc_seq_sampler
    import adc_seq_pkg::*;
#(
    parameter int ACQ_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             soc,
    input  logic             mode_simul,
    input  logic [ACQ_W-1:0] acq_ps,
    input  logic [CNT_W-1:0] max_conv,
    input  logic             cont_run,
    input  logic             drain_done,
    output logic             sh_pulse,
    output logic [CNT_W-1:0] chan_idx,
    output logic             push,
    output logic [CNT_W-1:0] push_slot,
    output logic             push_last,
    output logic             busy,
    output logic             cfg_simul,
    output logic [ACQ_W-1:0] cfg_acq
);

    localparam logic [SETTLE_W-1:0] SEQ_GAP_END  = SETTLE_W'(SEQ_SETTLE_TICKS - 1);
    localparam logic [SETTLE_W-1:0] PAIR_GAP_END = SETTLE_W'(PAIR_SETTLE_TICKS - 1);

    seq_state_e          state_q, state_d;
    logic [ACQ_W-1:0]    acq_q, acq_d;
    logic [SETTLE_W-1:0] gap_q, gap_d;
    logic [CNT_W-1:0]    idx_q, idx_d;
    logic [ACQ_W-1:0]    cfg_acq_q, cfg_acq_d;
    logic [CNT_W-1:0]    cfg_max_q, cfg_max_d;
    logic                cfg_simul_q, cfg_simul_d;

    logic acq_done;
    logic at_last;
    logic settle_done;

    assign acq_done    = (acq_q == cfg_acq_q);
    assign at_last     = cfg_simul_q ? (idx_q == {1'b0, cfg_max_q[CNT_W-2:0]})
                                     : (idx_q == cfg_max_q);
    assign settle_done = (gap_q == (cfg_simul_q ? PAIR_GAP_END : SEQ_GAP_END));

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        acq_d       = acq_q;
        gap_d       = gap_q;
        idx_d       = idx_q;
        cfg_acq_d   = cfg_acq_q;
        cfg_max_d   = cfg_max_q;
        cfg_simul_d = cfg_simul_q;
        unique case (state_q)
            ST_IDLE: begin
                if (soc) begin
                    state_d     = ST_ACQUIRE;
                    acq_d       = '0;
                    idx_d       = '0;
                    cfg_acq_d   = acq_ps;
                    cfg_max_d   = max_conv;
                    cfg_simul_d = mode_simul;
                end
            end
            ST_ACQUIRE: begin
                if (acq_done) begin
                    gap_d = '0;
                    if (at_last) begin
                        idx_d   = '0;
                        state_d = cont_run ? ST_SETTLE : ST_DRAIN;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_SETTLE;
                    end
                end else begin
                    acq_d = acq_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_d = ST_ACQUIRE;
                    acq_d   = '0;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (drain_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            acq_q       <= '0;
            gap_q       <= '0;
            idx_q       <= '0;
            cfg_acq_q   <= '0;
            cfg_max_q   <= '0;
            cfg_simul_q <= 1'b0;
        end else if (clk_en) begin
            state_q     <= state_d;
            acq_q       <= acq_d;
            gap_q       <= gap_d;
            idx_q       <= idx_d;
            cfg_acq_q   <= cfg_acq_d;
            cfg_max_q   <= cfg_max_d;
            cfg_simul_q <= cfg_simul_d;
        end
    end

    // Outputs
    always_comb begin
        sh_pulse  = 1'b0;
        chan_idx  = '0;
        push      = 1'b0;
        push_slot = idx_q;
        push_last = at_last;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_ACQUIRE: begin
                sh_pulse = 1'b1;
                chan_idx = idx_q;
                push     = acq_done;
            end
            ST_SETTLE: busy = 1'b1;
            ST_DRAIN:  busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign cfg_simul = cfg_simul_q;
    assign cfg_acq   = cfg_acq_q;

endmodule

// File: rtl/adc_seq_pipe.sv
`timescale 1ns/1ps
module adc_seq_pipe #(
    parameter int CNT_W      = 4,
    parameter int PIPE_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             push,
    input  logic [CNT_W-1:0] push_slot,
    input  logic             push_last,
    input  logic             pair_mode,
    output logic             res_valid_a,
    output logic [CNT_W-1:0] res_slot_a,
    output logic             res_valid_b,
    output logic [CNT_W-1:0] res_slot_b,
    output logic             eos
);

    localparam int LAST = PIPE_DEPTH - 1;

    logic [PIPE_DEPTH-1:0] v_q;
    logic [PIPE_DEPTH-1:0] last_q;
    logic [CNT_W-1:0]      slot_q [PIPE_DEPTH];

    logic                  b_v_q;
    logic                  b_last_q;
    logic [CNT_W-2:0]      b_pair_q;

    // Conversion pipeline, one stage per tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= '0;
            last_q <= '0;
            for (int s = 0; s < PIPE_DEPTH; s++) slot_q[s] <= '0;
        end else if (clk_en) begin
            v_q[0]    <= push;
            last_q[0] <= push_last;
            slot_q[0] <= push_slot;
            for (int s = 1; s < PIPE_DEPTH; s++) begin
                v_q[s]    <= v_q[s-1];
                last_q[s] <= last_q[s-1];
                slot_q[s] <= slot_q[s-1];
            end
        end
    end

    // Second channel of a pair trails the first by one tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_v_q    <= 1'b0;
            b_last_q <= 1'b0;
            b_pair_q <= '0;
        end else if (clk_en) begin
            b_v_q    <= v_q[LAST] & pair_mode;
            b_last_q <= last_q[LAST];
            b_pair_q <= slot_q[LAST][CNT_W-2:0];
        end
    end

    assign res_valid_a = v_q[LAST];
    assign res_slot_a  = pair_mode ? {slot_q[LAST][CNT_W-2:0], 1'b0} : slot_q[LAST];
    assign res_valid_b = b_v_q;
    assign res_slot_b  = {b_pair_q, 1'b1};
    assign eos         = pair_mode ? (b_v_q & b_last_q) : (v_q[LAST] & last_q[LAST]);

endmodule

// File: rtl/adc_seq_result_stub.sv
`timescale 1ns/1ps
module adc_seq_result_stub #(
    parameter int                 CNT_W = 4,
    parameter int                 TAG_W = 8,
    parameter logic [TAG_W-1:0]   TAG   = 8'hC3
) (
    input  logic                   valid,
    input  logic [CNT_W-1:0]       slot,
    output logic [TAG_W+CNT_W-1:0] code
);

    assign code = valid ? {TAG, slot} : '0;

endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
    parameter int               ACQ_W      = 6,
    parameter int               CNT_W      = 4,
    parameter int               PIPE_DEPTH = 4,
    parameter int               TAG_W      = 8,
    parameter logic [TAG_W-1:0] RES_TAG    = 8'hC3,
    localparam int              CODE_W     = TAG_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              soc,
    input  logic              mode_simul,
    input  logic [ACQ_W-1:0]  acq_ps,
    input  logic [CNT_W-1:0]  max_conv,
    input  logic              cont_run,
    output logic              sh_pulse,
    output logic [CNT_W-1:0]  chan_idx,
    output logic              res_valid_a,
    output logic [CNT_W-1:0]  res_slot_a,
    output logic [CODE_W-1:0] res_code_a,
    output logic              res_valid_b,
    output logic [CNT_W-1:0]  res_slot_b,
    output logic [CODE_W-1:0] res_code_b,
    output logic              eos
);

    localparam int N_CH = 2;

    logic             push;
    logic [CNT_W-1:0] push_slot;
    logic             push_last;
    logic             busy;
    logic             cfg_simul;
    logic [ACQ_W-1:0] cfg_acq;

    adc_seq_sampler #(
        .ACQ_W (ACQ_W),
        .CNT_W (CNT_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .soc        (soc),
        .mode_simul (mode_simul),
        .acq_ps     (acq_ps),
        .max_conv   (max_conv),
        .cont_run   (cont_run),
        .drain_done (eos),
        .sh_pulse   (sh_pulse),
        .chan_idx   (chan_idx),
        .push       (push),
        .push_slot  (push_slot),
        .push_last  (push_last),
        .busy       (busy),
        .cfg_simul  (cfg_simul),
        .cfg_acq    (cfg_acq)
    );

    adc_seq_pipe #(
        .CNT_W      (CNT_W),
        .PIPE_DEPTH (PIPE_DEPTH)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .push        (push),
        .push_slot   (push_slot),
        .push_last   (push_last),
        .pair_mode   (cfg_simul),
        .res_valid_a (res_valid_a),
        .res_slot_a  (res_slot_a),
        .res_valid_b (res_valid_b),
        .res_slot_b  (res_slot_b),
        .eos         (eos)
    );

    logic              ch_valid [N_CH];
    logic [CNT_W-1:0]  ch_slot  [N_CH];
    logic [CODE_W-1:0] ch_code  [N_CH];

    assign ch_valid[0] = res_valid_a;
    assign ch_valid[1] = res_valid_b;
    assign ch_slot[0]  = res_slot_a;
    assign ch_slot[1]  = res_slot_b;

    for (genvar c = 0; c < N_CH; c++) begin : g_stub
        adc_seq_result_stub #(
            .CNT_W (CNT_W),
            .TAG_W (TAG_W),
            .TAG   (RES_TAG)
        ) u_stub (
            .valid (ch_valid[c]),
            .slot  (ch_slot[c]),
            .code  (ch_code[c])
        );
    end

    assign res_code_a = ch_code[0];
    assign res_code_b = ch_code[1];

endmodule

// File: rtl/adc_seq_timer_chk.sv
`timescale 1ns/1ps
module adc_seq_timer_chk #(
    parameter int ACQ_W = 6,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             sh_pulse,
    input logic [CNT_W-1:0] chan_idx,
    input logic             res_valid_a,
    input logic             res_valid_b,
    input logic             eos,
    input logic             busy,
    input logic             cfg_simul,
    input logic [ACQ_W-1:0] cfg_acq
);

    logic             sh_prev;
    logic [ACQ_W:0]   sh_run;
    logic [ACQ_W+1:0] since_a;
    logic             had_prev;
    logic             a_prev;
    logic [ACQ_W+1:0] exp_gap;

    assign exp_gap = (ACQ_W+2)'(cfg_acq) + (ACQ_W+2)'(cfg_simul ? 4 : 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_prev  <= 1'b0;
            sh_run   <= '0;
            since_a  <= '0;
            had_prev <= 1'b0;
            a_prev   <= 1'b0;
        end else if (clk_en) begin
            sh_prev  <= sh_pulse;
            if (sh_pulse) sh_run <= sh_prev ? sh_run + 1'b1 : (ACQ_W+1)'(1);
            since_a  <= res_valid_a ? (ACQ_W+2)'(1) : since_a + 1'b1;
            a_prev   <= res_valid_a;
            if (!busy)            had_prev <= 1'b0;
            else if (res_valid_a) had_prev <= 1'b1;
        end
    end

    // R2
    sh_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sh_prev && !sh_pulse) |-> (sh_run == (ACQ_W+1)'(cfg_acq) + 1'b1));

    // R4
    result_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && res_valid_a && had_prev) |-> (since_a == exp_gap));

    // R6
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && res_valid_b) |-> a_prev);

    // R6
    seq_no_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_simul) |-> !res_valid_b);

    // R7
    eos_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> (cfg_simul ? res_valid_b : res_valid_a));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sh_pulse);

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable({sh_pulse, chan_idx, res_valid_a, res_valid_b, eos}));

endmodule

bind adc_seq_timer adc_seq_timer_chk #(
    .ACQ_W (ACQ_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .sh_pulse    (sh_pulse),
    .chan_idx    (chan_idx),
    .res_valid_a (res_valid_a),
    .res_valid_b (res_valid_b),
    .eos         (eos),
    .busy        (busy),
    .cfg_simul   (cfg_simul),
    .cfg_acq     (cfg_acq)
);

// File: tb/adc_seq_timer_bench.sv
`timescale 1ns/1ps
module adc_seq_timer_bench;

    localparam int TAG = 'hC3;
    localparam int LOG = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        soc = 1'b0;
    logic        mode_simul = 1'b0;
    logic [5:0]  acq_ps = '0;
    logic [3:0]  max_conv = '0;
    logic        cont_run = 1'b0;
    logic        sh_pulse;
    logic [3:0]  chan_idx;
    logic        res_valid_a;
    logic [3:0]  res_slot_a;
    logic [11:0] res_code_a;
    logic        res_valid_b;
    logic [3:0]  res_slot_b;
    logic [11:0] res_code_b;
    logic        eos;

    adc_seq_timer u_adc_seq_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .soc(soc),
        .mode_simul(mode_simul), .acq_ps(acq_ps), .max_conv(max_conv),
        .cont_run(cont_run), .sh_pulse(sh_pulse), .chan_idx(chan_idx),
        .res_valid_a(res_valid_a), .res_slot_a(res_slot_a), .res_code_a(res_code_a),
        .res_valid_b(res_valid_b), .res_slot_b(res_slot_b), .res_code_b(res_code_b),
        .eos(eos)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick = 0;
    bit half = 1'b0;

    int a_tick [LOG]; int a_slot [LOG]; int a_code [LOG]; int a_cyc [LOG];
    int b_tick [LOG]; int b_slot [LOG]; int b_code [LOG];
    int e_tick [LOG];
    int r_tick [LOG]; int r_chan [LOG];
    int na, nb, ne, nr, sh_total;
    bit sh_seen;

    // Tick enable: held high, or alternating when half is set
    always @(posedge clk) begin
        #1;
        clk_en <= half ? ~clk_en : 1'b1;
    end

    // Monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && clk_en) begin
            tick++;
            if (res_valid_a && na < LOG) begin
                a_tick[na] = tick; a_slot[na] = res_slot_a;
                a_code[na] = res_code_a; a_cyc[na] = cyc; na++;
            end
            if (res_valid_b && nb < LOG) begin
                b_tick[nb] = tick; b_slot[nb] = res_slot_b; b_code[nb] = res_code_b; nb++;
            end
            if (eos && ne < LOG) begin e_tick[ne] = tick; ne++; end
            if (sh_pulse) begin
                sh_total++;
                if (!sh_seen && nr < LOG) begin r_tick[nr] = tick; r_chan[nr] = chan_idx; nr++; end
            end
            sh_seen = sh_pulse;
        end
    end

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary_and_end();
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        na = 0; nb = 0; ne = 0; nr = 0; sh_total = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic fire(output int t0);
        @(posedge clk); #2;
        while (!clk_en) begin @(posedge clk); #2; end
        soc = 1'b1;
        @(posedge clk);
        t0 = tick;
        #2 soc = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1", "sh_pulse", int'(sh_pulse), 0);
        chk_eq("R1", "res_valid_a", int'(res_valid_a), 0);
        chk_eq("R1", "res_valid_b", int'(res_valid_b), 0);
        chk_eq("R1", "eos", int'(eos), 0);
        chk_eq("R1", "chan_idx", int'(chan_idx), 0);
        chk_eq("R1", "res_code_a", int'(res_code_a), 0);
        chk_eq("R1", "res_code_b", int'(res_code_b), 0);
    endtask

    task automatic check_seq(input int t0, input int acq, input int n);
        chk_eq("R7", "sequential result count", na, n);
        chk_eq("R2", "window ticks", sh_total, n * (acq + 1));
        for (int k = 0; k < n && k < na; k++) begin
            chk_eq(k == 0 ? "R3" : "R4", "sequential result tick", a_tick[k], t0 + acq + 5 + k * (acq + 2));
            chk_eq("R4", "sequential slot", a_slot[k], k);
            chk_eq("R11", "result code", a_code[k], TAG * 16 + k);
        end
        for (int k = 0; k < n && k < nr; k++) begin
            chk_eq(k == 0 ? "R2" : "R4", "window open tick", r_tick[k], t0 + 1 + k * (acq + 2));
            chk_eq("R2", "chan_idx in window", r_chan[k], k);
        end
        chk_eq("R7", "eos count", ne, 1);
        if (ne > 0) chk_eq("R7", "eos tick", e_tick[0], t0 + acq + 5 + (n - 1) * (acq + 2));
        chk_eq("R6", "no second strobe in sequential", nb, 0);
    endtask

    task automatic run_seq(input int acq, input int maxc);
        int t0;
        clear_logs();
        mode_simul = 1'b0; acq_ps = 6'(acq); max_conv = 4'(maxc); cont_run = 1'b0;
        fire(t0);
        wait_cycles(2 * (maxc + 3) * (acq + 5) + 20);
        check_seq(t0, acq, maxc + 1);
    endtask

    task automatic run_sim(input int acq, input int maxc);
        int t0, np, ta;
        clear_logs();
        mode_simul = 1'b1; acq_ps = 6'(acq); max_conv = 4'(maxc); cont_run = 1'b0;
        fire(t0);
        np = (maxc % 8) + 1;
        wait_cycles(2 * (np + 3) * (acq + 5) + 20);
        chk_eq("R7", "pair count first channel", na, np);
        chk_eq("R7", "pair count second channel", nb, np);
        chk_eq("R2", "window ticks in pair mode", sh_total, np * (acq + 1));
        for (int p = 0; p < np && p < na && p < nb; p++) begin
            ta = t0 + acq + 5 + p * (acq + 4);
            chk_eq(p == 0 ? "R3" : "R5", "pair first tick", a_tick[p], ta);
            chk_eq("R6", "pair second tick", b_tick[p], ta + 1);
            chk_eq("R6", "pair first slot", a_slot[p], 2 * p);
            chk_eq("R6", "pair second slot", b_slot[p], 2 * p + 1);
            chk_eq("R11", "second code", b_code[p], TAG * 16 + 2 * p + 1);
        end
        for (int p = 0; p < np && p < nr; p++) begin
            chk_eq("R5", "pair window open tick", r_tick[p], t0 + 1 + p * (acq + 4));
            chk_eq("R2", "pair index in window", r_chan[p], p);
        end
        chk_eq("R7", "pair eos count", ne, 1);
        if (ne > 0) chk_eq("R7", "pair eos tick", e_tick[0], t0 + acq + 6 + (np - 1) * (acq + 4));
    endtask

    // R9: trigger and setting changes while active are ignored
    task automatic run_ignore();
        int t0;
        clear_logs();
        mode_simul = 1'b0; acq_ps = 6'd3; max_conv = 4'd3; cont_run = 1'b0;
        fire(t0);
        wait_cycles(6);
        mode_simul = 1'b1; acq_ps = 6'd0; max_conv = 4'd0; soc = 1'b1;
        wait_cycles(1);
        soc = 1'b0;
        wait_cycles(60);
        chk_eq("R9", "sequence unaffected by late trigger", na, 4);
        check_seq(t0, 3, 4);
    endtask

    // R8: continuous run
    task automatic run_cont();
        int t0;
        clear_logs();
        mode_simul = 1'b0; acq_ps = 6'd0; max_conv = 4'd2; cont_run = 1'b1;
        fire(t0);
        wait_cycles(25);
        cont_run = 1'b0;
        wait_cycles(40);
        chk_eq("R8", "whole sequences", na % 3, 0);
        chk_eq("R8", "at least two sequences", int'(na >= 6), 1);
        chk_eq("R8", "eos per sequence", ne, na / 3);
        for (int k = 0; k < na; k++) begin
            chk_eq("R8", "gapless result tick", a_tick[k], t0 + 5 + 2 * k);
            chk_eq("R8", "wrapping slot", a_slot[k], k % 3);
        end
        for (int j = 0; j < ne && 3 * j + 2 < na; j++)
            chk_eq("R8", "eos on last slot", e_tick[j], a_tick[3 * j + 2]);
    endtask

    // R10: half-rate ticks
    task automatic run_half();
        half = 1'b1;
        wait_cycles(4);
        run_sim(3, 1);
        if (na >= 2) chk_eq("R10", "pair spacing in clock cycles", a_cyc[1] - a_cyc[0], 2 * (3 + 4));
        half = 1'b0;
        wait_cycles(4);
    endtask

    initial begin
        clear_logs();
        sh_seen = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        wait_cycles(3);
        t_reset();
        run_seq(0, 3);
        run_seq(3, 2);
        run_seq(47, 2);
        run_seq(0, 15);
        run_sim(0, 4'b1010);
        run_sim(3, 1);
        run_sim(47, 1);
        run_ignore();
        run_cont();
        run_half();
        summary_and_end();
    end

endmodule